// File: doc/BRIEF.md
# Buffered Prescaled Up-Counting Timer

This block is the time base of a general-purpose timer. A main counter climbs from zero to a programmable reload limit and then returns to zero. Each return is an overflow. The counter advances only on ticks from a prescaler, and the prescaler divides the enabled system clock by a programmable ratio.

A repetition stage sets how many overflows must pass before an update event is raised. At an update event the buffered copies of the prescaler ratio and of the reload limit become the active values, and the repetition count is restored. Software writes only the preload copies, so a write never disturbs the period that is running. Software can also force an update at once, or hold updates back while it rewrites several values.

A control write carries two bits. Bit 0 is the update-disable flag and is stored. Bit 1 requests a forced update and acts only in the cycle of the write.

Top module: `prescaled_uptimer`

## Requirements
- R1: With the active reload limit A, the counter value runs 0, 1, …, A and then returns to 0. The `ovf` output pulses high for one cycle in the cycle that follows each return to 0.
- R2: With the active prescaler value P, the counter advances by one every P+1 enabled clock cycles, so one full wrap takes (A+1)·(P+1) enabled cycles.
- R3: With the active repetition value R, an update event is raised on every (R+1)-th overflow. With R = 0, every overflow raises one.
- R4: `uev` is a one-cycle pulse. It rises in the same cycle in which the counter shows 0 after the update.
- R5: A prescaler write changes only the preload copy. The old ratio stays in force until the next update event, and the new ratio applies from that event on.
- R6: A reload-limit write changes only the preload copy. The old limit stays in force until the next update event.
- R7: A control write with bit 1 set forces an update in the next cycle. The counter and prescaler go to 0, `uev` pulses, and the prescaler, reload and repetition preloads are all transferred. This happens whatever the state of bit 0 and of the repetition count.
- R8: While the stored update-disable flag (control bit 0) is 1, overflows still wrap the counter to 0 and pulse `ovf`. No `uev` is produced and no preload is transferred.
- R9: While `cnt_en` is low and no forced update is requested, the counter and prescaler hold their state and neither `uev` nor `ovf` pulses.
- R10: After reset the counter is 0, `uev` and `ovf` are low, the update-disable flag is 0, the active prescaler is 0, the active reload limit is all ones and the repetition value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| psc_we | input | 1 | Write strobe for the prescaler preload |
| psc_wdata | input | PSC_W | Prescaler value; ratio is value plus one |
| arr_we | input | 1 | Write strobe for the reload-limit preload |
| arr_wdata | input | CNT_W | Reload limit |
| rep_we | input | 1 | Write strobe for the repetition preload |
| rep_wdata | input | REP_W | Overflows per update, minus one |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0 update-disable flag, bit 1 force update |
| cnt_value | output | CNT_W | Current counter value |
| ovf | output | 1 | One-cycle overflow pulse |
| uev | output | 1 | One-cycle update event pulse |

## Verification
The hardest case is a preload value that must stay inactive while the counter runs. A new ratio or limit written in the middle of a period must leave the rest of that period unchanged. Under the update-disable flag, it must also survive several overflows and then take effect at the first overflow after the flag clears. The bench reaches these cases by writing the preloads at known distances from an update. It then predicts every counter value and pulse from the elapsed enabled cycles, one segment at a time. A full sweep over small ratio, limit and repetition values, together with a forced update in mid-count, covers the repetition reload.

// File: rtl/utm_pkg.sv
`timescale 1ns/1ps
package utm_pkg;
  localparam int CTL_W        = 2;
  localparam int CTL_UDIS_BIT = 0;
  localparam int CTL_FORCE_BIT = 1;
endpackage

// File: rtl/utm_prescaler.sv
`timescale 1ns/1ps
module utm_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             upd,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  output logic             tick
);
  logic [PSC_W-1:0] pre_q, act_q, div_q;

  assign tick = en && (div_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act_q <= '0;
      div_q <= '0;
    end else begin
      if (psc_we) pre_q <= psc_wdata;
      if (upd) begin
        act_q <= pre_q;
        div_q <= '0;
      end else if (en) begin
        div_q <= tick ? '0 : div_q + 1'b1;
      end
    end
  end

  // R5: active ratio moves only on an update event
  assert_psc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(act_q));
  // R9: divider frozen while disabled and no update
  assert_div_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !upd) |=> $stable(div_q));
endmodule

// File: rtl/utm_counter.sv
`timescale 1ns/1ps
module utm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             upd,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic [CNT_W-1:0] pre_q, act_q;

  assign wrap = tick && (cnt_q == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '1;
      act_q <= '1;
      cnt_q <= '0;
    end else begin
      if (arr_we) pre_q <= arr_wdata;
      if (upd) begin
        act_q <= pre_q;
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  end

  // R1: counter never passes the active limit
  assert_cnt_le_arr_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= act_q);
  // R6: active limit moves only on an update event
  assert_arr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(act_q));
endmodule

// File: rtl/utm_repcnt.sv
`timescale 1ns/1ps
module utm_repcnt #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             upd,
  input  logic             rep_we,
  input  logic [REP_W-1:0] rep_wdata,
  output logic             rep_zero
);
  logic [REP_W-1:0] pre_q, rem_q;

  assign rep_zero = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      rem_q <= '0;
    end else begin
      if (rep_we) pre_q <= rep_wdata;
      if (upd) rem_q <= pre_q;
      else if (wrap && !rep_zero) rem_q <= rem_q - 1'b1;
    end
  end

  // R3: remaining count changes only on an overflow or an update
  assert_rep_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !upd) |=> $stable(rem_q));
endmodule

// File: rtl/prescaled_uptimer.sv
`timescale 1ns/1ps
module prescaled_uptimer
  import utm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             psc_we,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             arr_we,
  input  logic [CNT_W-1:0] arr_wdata,
  input  logic             rep_we,
  input  logic [REP_W-1:0] rep_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CNT_W-1:0] cnt_value,
  output logic             ovf,
  output logic             uev
);
  logic udis_q, force_upd, upd, tick, wrap, rep_zero;
  logic uev_q, ovf_q;
  logic [CNT_W-1:0] cnt_q;

  assign force_upd = ctl_we && ctl_wdata[CTL_FORCE_BIT];
  assign upd = force_upd || (wrap && rep_zero && !udis_q);

  utm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .en(cnt_en), .upd(upd),
    .psc_we(psc_we), .psc_wdata(psc_wdata), .tick(tick)
  );

  utm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .upd(upd),
    .arr_we(arr_we), .arr_wdata(arr_wdata), .cnt_q(cnt_q), .wrap(wrap)
  );

  utm_repcnt #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst(rst), .wrap(wrap), .upd(upd),
    .rep_we(rep_we), .rep_wdata(rep_wdata), .rep_zero(rep_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      udis_q <= 1'b0;
      uev_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctl_we) udis_q <= ctl_wdata[CTL_UDIS_BIT];
      uev_q <= upd;
      ovf_q <= wrap;
    end
  end

  assign cnt_value = cnt_q;
  assign uev = uev_q;
  assign ovf = ovf_q;

  // R4: an update pulse is seen with the counter at zero
  assert_uev_zero_R4: assert property (@(posedge clk) disable iff (rst)
    uev |-> (cnt_value == '0));
  // R8: stored disable flag blocks overflow-driven updates
  assert_udis_block_R8: assert property (@(posedge clk) disable iff (rst)
    (udis_q && !force_upd) |=> !uev);
  // R7: a forced update always yields a pulse
  assert_force_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    force_upd |=> (uev && cnt_value == '0));
  // R9: counter frozen while disabled and no forced update
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !force_upd) |=> ($stable(cnt_value) && !ovf));
endmodule

// File: tb/prescaled_uptimer_tb.sv
`timescale 1ns/1ps
module prescaled_uptimer_tb;
  localparam int CNT_W = 4;
  localparam int PSC_W = 3;
  localparam int REP_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic psc_we = 1'b0, arr_we = 1'b0, rep_we = 1'b0, ctl_we = 1'b0;
  logic [PSC_W-1:0] psc_wdata = '0;
  logic [CNT_W-1:0] arr_wdata = '0;
  logic [REP_W-1:0] rep_wdata = '0;
  logic [1:0] ctl_wdata = '0;
  logic [CNT_W-1:0] cnt_value;
  logic ovf, uev;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prescaled_uptimer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en),
    .psc_we(psc_we), .psc_wdata(psc_wdata),
    .arr_we(arr_we), .arr_wdata(arr_wdata),
    .rep_we(rep_we), .rep_wdata(rep_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_value(cnt_value), .ovf(ovf), .uev(uev)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_wr();
    psc_we = 1'b0; arr_we = 1'b0; rep_we = 1'b0; ctl_we = 1'b0;
  endtask

  // one cycle: edge, then drop strobes and sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr_wr();
  endtask

  // checks n enabled cycles; k counts enabled cycles since the last update
  task automatic expect_run(input int n, input int p, input int a, input int r,
                            input int k0, input bit upd_ok, input string req);
    int wrap_len = (a + 1) * (p + 1);
    int period = wrap_len * (r + 1);
    for (int i = 1; i <= n; i++) begin
      int k = k0 + i;
      int ec = (k / (p + 1)) % (a + 1);
      int eo = (k % wrap_len == 0) ? 1 : 0;
      int eu = (upd_ok && (k % period == 0)) ? 1 : 0;
      step();
      chk(int'(cnt_value) == ec, {req, " cnt R1 R2"}, int'(cnt_value), ec);
      chk(int'(ovf) == eo, {req, " ovf R1"}, int'(ovf), eo);
      chk(int'(uev) == eu, {req, " uev R3 R4"}, int'(uev), eu);
    end
  endtask

  // load preloads then force an update; ends with k = 0
  task automatic cfg(input int p, input int a, input int r);
    psc_we = 1'b1; psc_wdata = PSC_W'(p);
    arr_we = 1'b1; arr_wdata = CNT_W'(a);
    rep_we = 1'b1; rep_wdata = REP_W'(r);
    step();
    ctl_we = 1'b1; ctl_wdata = 2'b10;
    step();
    chk(uev == 1'b1, "R7 forced uev", int'(uev), 1);
    chk(cnt_value == '0, "R7 forced cnt", int'(cnt_value), 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(cnt_value == '0, "R10 cnt", int'(cnt_value), 0);
    chk(uev == 1'b0, "R10 uev", int'(uev), 0);
    chk(ovf == 1'b0, "R10 ovf", int'(ovf), 0);
    cnt_en = 1'b1;
    // R10: prescaler 0 and limit all ones: counts every cycle, wraps after 15
    for (int i = 1; i <= 17; i++) begin
      step();
      chk(int'(cnt_value) == i % 16, "R10 default count", int'(cnt_value), i % 16);
      chk(int'(ovf) == ((i == 16) ? 1 : 0), "R10 default ovf", int'(ovf), (i == 16) ? 1 : 0);
      chk(uev == 1'b0 || i == 16, "R10 default uev", int'(uev), 0);
    end

    // sweep over ratio, limit and repetition (R1 R2 R3 R4)
    for (int p = 0; p <= 3; p++)
      for (int a = 0; a <= 4; a++)
        for (int r = 0; r <= 2; r++) begin
          cfg(p, a, r);
          expect_run(2 * (a + 1) * (p + 1) * (r + 1) + 3, p, a, r, 0, 1'b1, "sweep");
        end

    // R5 R6: mid-period writes wait for the next update
    cfg(1, 3, 0);
    expect_run(3, 1, 3, 0, 0, 1'b1, "R5 R6 old");
    psc_we = 1'b1; psc_wdata = 3'd3;
    arr_we = 1'b1; arr_wdata = 4'd2;
    expect_run(5, 1, 3, 0, 3, 1'b1, "R5 R6 old");
    expect_run(30, 3, 2, 0, 0, 1'b1, "R5 R6 new");

    // R8: disable flag blocks updates and transfers, overflows still wrap
    cfg(0, 4, 0);
    ctl_we = 1'b1; ctl_wdata = 2'b01;
    expect_run(2, 0, 4, 0, 0, 1'b1, "R8 set");
    arr_we = 1'b1; arr_wdata = 4'd2;
    expect_run(13, 0, 4, 0, 2, 1'b0, "R8 blocked");
    ctl_we = 1'b1; ctl_wdata = 2'b00;
    expect_run(5, 0, 4, 0, 15, 1'b1, "R8 cleared");
    expect_run(6, 0, 2, 0, 0, 1'b1, "R8 new limit");

    // R9: enable low holds everything
    cfg(1, 3, 1);
    expect_run(5, 1, 3, 1, 0, 1'b1, "R9 pre");
    cnt_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(int'(cnt_value) == 2, "R9 hold cnt", int'(cnt_value), 2);
      chk(uev == 1'b0 && ovf == 1'b0, "R9 hold pulses", int'({uev, ovf}), 0);
    end
    cnt_en = 1'b1;
    expect_run(20, 1, 3, 1, 5, 1'b1, "R9 resume");

    // R7: forced update mid-count reloads the repetition counter
    cfg(0, 2, 2);
    expect_run(5, 0, 2, 2, 0, 1'b1, "R7 pre");
    ctl_we = 1'b1; ctl_wdata = 2'b10;
    step();
    chk(uev == 1'b1, "R7 mid uev", int'(uev), 1);
    chk(cnt_value == '0, "R7 mid cnt", int'(cnt_value), 0);
    expect_run(20, 0, 2, 2, 0, 1'b1, "R7 rep reload");
    // R7: forced update works with the disable flag set
    ctl_we = 1'b1; ctl_wdata = 2'b11;
    step();
    chk(uev == 1'b1, "R7 force under disable", int'(uev), 1);
    chk(cnt_value == '0, "R7 force under disable cnt", int'(cnt_value), 0);
    step();
    chk(uev == 1'b0, "R4 single pulse", int'(uev), 0);
    ctl_we = 1'b1; ctl_wdata = 2'b00;
    step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule